// File: doc/BRIEF.md
# Graphics Fill Engine

The block carries out bulk writes to two display memories on behalf of a host: a character screen of 80 by 25 cells, each a 16-bit word holding a character code and an attribute, and a bitmap of three 1-bit-per-pixel colour planes (red, green, blue) at 640 by 200 pixels. Each plane is 80 bytes per row and 16000 bytes in total. The three planes share one address and one per-bit write mask.

The host loads operands one byte at a time through a parameter port. It then writes a command code to a command port. The engine walks the target addresses and issues one write per clock. The busy and done outputs report progress, and the host waits for done before it issues the next command. Three operations exist. The first fills every character cell with one word. The second paints a clipped pixel rectangle in a 3-bit colour, and partial bytes at the edges are protected by the write mask. The third zeroes all three planes.

Top module: `gfx_fill_engine`

## Requirements
- R1: After reset, busy_o and done_o are 0 and neither write enable is asserted.
- R2: Parameter bytes fill a nine-entry file in this order: X start low, X start high, Y start, width low, width high, height, colour (bits 2:0), character, attribute. Bytes written after the ninth are dropped. Every accepted or ignored command write returns the pointer to the first entry.
- R3: Command code 0x01 writes the word {attribute, character} to every cell, at addresses 0 through 1999 in ascending order, one per clock.
- R4: Command code 0x03 writes zero data with an all-ones mask to every plane byte, at addresses 0 through 15999 in ascending order.
- R5: Command code 0x02 writes rows from Y start downwards, and within each row the byte columns from left to right. The byte address is y*80 + x/8. Pixel x maps to bit 7-(x mod 8). The mask covers exactly the pixels inside the rectangle. Each plane's data byte repeats its colour bit: red is bit 0, green is bit 1 and blue is bit 2. gram_wdata_o is {blue, green, red}.
- R6: The rectangle is clipped at pixel 640 on the right and at row 200 at the bottom. A rectangle that is empty after clipping produces no write.
- R7: After an accepted command, busy_o is high from the next cycle for exactly as many cycles as writes are issued. done_o is 0 while busy_o is high and becomes 1 when the last write completes.
- R8: A command written while busy_o is high is ignored. The running operation and its write count are unchanged.
- R9: Any other command code produces no write. busy_o stays low and done_o is 1 in the next cycle.
- R10: Parameters are captured when a command starts. A parameter byte written in the same cycle as a command is stored, but the starting command does not use it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| param_we_i | input | 1 | Store param_data_i at the parameter pointer |
| param_data_i | input | 8 | Parameter byte |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_data_i | input | 8 | Command code |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Last command finished |
| vram_we_o | output | 1 | Character memory write enable |
| vram_addr_o | output | 11 | Character cell address |
| vram_wdata_o | output | 16 | {attribute, character} |
| gram_we_o | output | 1 | Plane write enable, applied to all three planes |
| gram_addr_o | output | 14 | Plane byte address |
| gram_wdata_o | output | 24 | {blue, green, red} plane bytes |
| gram_mask_o | output | 8 | Per-bit write mask shared by the planes |

## Verification
A parameter write and a command write can fall on the same clock edge. The bench provokes this by loading eight parameter bytes and then, in a single cycle, issuing a character fill together with the ninth byte. The written stream must carry the previous attribute, and a following fill must carry the new one. A command write can also arrive while a walk is running. The bench checks that such a write neither disturbs the address stream nor adds writes, using a bench model that predicts every address, mask and data word.

// File: rtl/gfx_fill_pkg.sv
package gfx_fill_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_VCLR = 2'd1,
    OP_RECT = 2'd2,
    OP_GCLR = 2'd3
  } op_e;

  localparam logic [7:0] CMD_VCLR = 8'h01;
  localparam logic [7:0] CMD_RECT = 8'h02;
  localparam logic [7:0] CMD_GCLR = 8'h03;

  localparam int unsigned PARAM_BYTES = 9;

  typedef struct packed {
    logic [15:0] x0;
    logic [7:0]  y0;
    logic [15:0] w;
    logic [7:0]  h;
    logic [2:0]  colour;
    logic [7:0]  chr;
    logic [7:0]  attr;
  } fill_params_t;
endpackage

// File: rtl/gfx_param_regs.sv
module gfx_param_regs
  import gfx_fill_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [7:0]   data_i,
  input  logic         restart_i,
  output fill_params_t params_o
);
  localparam int unsigned IW = $clog2(PARAM_BYTES + 1);

  logic [IW-1:0] idx_q;
  logic [7:0]    byte_q [PARAM_BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   idx_q <= '0;
    else if (restart_i)                            idx_q <= '0;
    else if (wr_i && idx_q < IW'(PARAM_BYTES))     idx_q <= idx_q + 1'b1;
  end

  for (genvar g = 0; g < PARAM_BYTES; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              byte_q[g] <= '0;
      else if (wr_i && idx_q == IW'(g))         byte_q[g] <= data_i;
    end
  end

  assign params_o.x0     = {byte_q[1], byte_q[0]};
  assign params_o.y0     = byte_q[2];
  assign params_o.w      = {byte_q[4], byte_q[3]};
  assign params_o.h      = byte_q[5];
  assign params_o.colour = byte_q[6][2:0];
  assign params_o.chr    = byte_q[7];
  assign params_o.attr   = byte_q[8];
endmodule

// File: rtl/gfx_rect_setup.sv
module gfx_rect_setup #(
  parameter int unsigned PIX_W = 640,
  parameter int unsigned PIX_H = 200,
  localparam int unsigned BPR  = PIX_W / 8,
  localparam int unsigned CW   = $clog2(BPR),
  localparam int unsigned GAW  = $clog2(BPR * PIX_H)
) (
  input  logic [15:0]    x0_i,
  input  logic [7:0]     y0_i,
  input  logic [15:0]    w_i,
  input  logic [7:0]     h_i,
  output logic           empty_o,
  output logic [CW-1:0]  bcol_first_o,
  output logic [CW-1:0]  bcol_last_o,
  output logic [7:0]     lmask_o,
  output logic [7:0]     rmask_o,
  output logic [7:0]     row_end_o,
  output logic [GAW-1:0] row_base_o
);
  logic [16:0] xe_raw, xe, x_last;
  logic [8:0]  ye_raw, ye;

  always_comb begin
    xe_raw  = {1'b0, x0_i} + {1'b0, w_i};
    xe      = (xe_raw > 17'(PIX_W)) ? 17'(PIX_W) : xe_raw;
    ye_raw  = {1'b0, y0_i} + {1'b0, h_i};
    ye      = (ye_raw > 9'(PIX_H)) ? 9'(PIX_H) : ye_raw;
    // x0 beyond the right edge also yields xe <= x0
    empty_o = (xe <= {1'b0, x0_i}) || (ye <= {1'b0, y0_i});
    x_last  = xe - 17'd1;
  end

  assign bcol_first_o = CW'(x0_i >> 3);
  assign bcol_last_o  = CW'(x_last >> 3);
  assign lmask_o      = 8'hFF >> x0_i[2:0];
  assign rmask_o      = 8'hFF << (3'd7 - x_last[2:0]);
  assign row_end_o    = ye[7:0];
  assign row_base_o   = GAW'(32'(y0_i) * BPR);
endmodule

// File: rtl/gfx_walker.sv
module gfx_walker
  import gfx_fill_pkg::*;
#(
  parameter int unsigned VCELLS = 2000,
  parameter int unsigned BPR    = 80,
  parameter int unsigned GBYTES = 16000,
  localparam int unsigned VAW   = $clog2(VCELLS),
  localparam int unsigned GAW   = $clog2(GBYTES),
  localparam int unsigned CW    = $clog2(BPR),
  localparam int unsigned LAW   = (VAW > GAW) ? VAW : GAW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           accept_i,
  input  logic           start_i,
  input  op_e            op_i,
  input  logic [CW-1:0]  bcol_first_i,
  input  logic [CW-1:0]  bcol_last_i,
  input  logic [7:0]     lmask_i,
  input  logic [7:0]     rmask_i,
  input  logic [7:0]     row_first_i,
  input  logic [7:0]     row_end_i,
  input  logic [GAW-1:0] row_base_i,
  input  logic [2:0]     colour_i,
  input  logic [15:0]    cell_i,
  output logic           busy_o,
  output logic           done_o,
  output logic           vram_we_o,
  output logic [VAW-1:0] vram_addr_o,
  output logic [15:0]    vram_wdata_o,
  output logic           gram_we_o,
  output logic [GAW-1:0] gram_addr_o,
  output logic [23:0]    gram_wdata_o,
  output logic [7:0]     gram_mask_o
);
  logic           run_q, done_q;
  op_e            op_q;
  logic [LAW-1:0] lin_q;
  logic [CW-1:0]  col_q, cfirst_q, clast_q;
  logic [7:0]     lmask_q, rmask_q, row_q, rend_q;
  logic [GAW-1:0] rbase_q;
  logic [2:0]     colour_q;
  logic [15:0]    cell_q;
  logic           last;
  logic           row_done;

  assign row_done = (col_q == clast_q);

  always_comb begin
    last = 1'b0;
    if (run_q) begin
      unique case (op_q)
        OP_VCLR: last = (lin_q == LAW'(VCELLS - 1));
        OP_GCLR: last = (lin_q == LAW'(GBYTES - 1));
        OP_RECT: last = row_done && (row_q == rend_q - 8'd1);
        default: last = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (start_i)   run_q <= 1'b1;
      else if (last) run_q <= 1'b0;
      if (accept_i)  done_q <= !start_i;
      else if (last) done_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q     <= OP_NONE;
      lin_q    <= '0;
      col_q    <= '0;
      cfirst_q <= '0;
      clast_q  <= '0;
      lmask_q  <= '0;
      rmask_q  <= '0;
      row_q    <= '0;
      rend_q   <= '0;
      rbase_q  <= '0;
      colour_q <= '0;
      cell_q   <= '0;
    end else if (start_i) begin
      op_q     <= op_i;
      lin_q    <= '0;
      col_q    <= bcol_first_i;
      cfirst_q <= bcol_first_i;
      clast_q  <= bcol_last_i;
      lmask_q  <= lmask_i;
      rmask_q  <= rmask_i;
      row_q    <= row_first_i;
      rend_q   <= row_end_i;
      rbase_q  <= row_base_i;
      colour_q <= colour_i;
      cell_q   <= cell_i;
    end else if (run_q && !last) begin
      lin_q <= lin_q + 1'b1;
      if (op_q == OP_RECT) begin
        if (row_done) begin
          col_q   <= cfirst_q;
          row_q   <= row_q + 8'd1;
          rbase_q <= rbase_q + GAW'(BPR);
        end else begin
          col_q <= col_q + 1'b1;
        end
      end
    end
  end

  logic is_rect;
  assign is_rect = (op_q == OP_RECT);

  assign busy_o       = run_q;
  assign done_o       = done_q;
  assign vram_we_o    = run_q && (op_q == OP_VCLR);
  assign vram_addr_o  = VAW'(lin_q);
  assign vram_wdata_o = cell_q;
  assign gram_we_o    = run_q && (is_rect || op_q == OP_GCLR);
  assign gram_addr_o  = is_rect ? rbase_q + GAW'(col_q) : GAW'(lin_q);
  assign gram_mask_o  = is_rect ? ((col_q == cfirst_q ? lmask_q : 8'hFF) &
                                   (col_q == clast_q  ? rmask_q : 8'hFF))
                                : 8'hFF;

  for (genvar p = 0; p < 3; p++) begin : g_plane
    assign gram_wdata_o[p*8 +: 8] = is_rect ? {8{colour_q[p]}} : 8'h00;
  end
endmodule

// File: rtl/gfx_fill_engine.sv
module gfx_fill_engine
  import gfx_fill_pkg::*;
#(
  parameter int unsigned TXT_COLS = 80,
  parameter int unsigned TXT_ROWS = 25,
  parameter int unsigned PIX_W    = 640,
  parameter int unsigned PIX_H    = 200,
  localparam int unsigned VCELLS  = TXT_COLS * TXT_ROWS,
  localparam int unsigned VAW     = $clog2(VCELLS),
  localparam int unsigned BPR     = PIX_W / 8,
  localparam int unsigned GBYTES  = BPR * PIX_H,
  localparam int unsigned GAW     = $clog2(GBYTES),
  localparam int unsigned CW      = $clog2(BPR)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           param_we_i,
  input  logic [7:0]     param_data_i,
  input  logic           cmd_we_i,
  input  logic [7:0]     cmd_data_i,
  output logic           busy_o,
  output logic           done_o,
  output logic           vram_we_o,
  output logic [VAW-1:0] vram_addr_o,
  output logic [15:0]    vram_wdata_o,
  output logic           gram_we_o,
  output logic [GAW-1:0] gram_addr_o,
  output logic [23:0]    gram_wdata_o,
  output logic [7:0]     gram_mask_o
);
  fill_params_t   prm;
  op_e            op_dec;
  logic           accept, start;
  logic           rect_empty;
  logic [CW-1:0]  bcol_first, bcol_last;
  logic [7:0]     lmask, rmask, row_end;
  logic [GAW-1:0] row_base;

  gfx_param_regs u_params (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (param_we_i),
    .data_i    (param_data_i),
    .restart_i (cmd_we_i),
    .params_o  (prm)
  );

  gfx_rect_setup #(.PIX_W(PIX_W), .PIX_H(PIX_H)) u_setup (
    .x0_i         (prm.x0),
    .y0_i         (prm.y0),
    .w_i          (prm.w),
    .h_i          (prm.h),
    .empty_o      (rect_empty),
    .bcol_first_o (bcol_first),
    .bcol_last_o  (bcol_last),
    .lmask_o      (lmask),
    .rmask_o      (rmask),
    .row_end_o    (row_end),
    .row_base_o   (row_base)
  );

  always_comb begin
    unique case (cmd_data_i)
      CMD_VCLR: op_dec = OP_VCLR;
      CMD_RECT: op_dec = OP_RECT;
      CMD_GCLR: op_dec = OP_GCLR;
      default:  op_dec = OP_NONE;
    endcase
  end

  assign accept = cmd_we_i && !busy_o;
  assign start  = accept && (op_dec != OP_NONE) && !(op_dec == OP_RECT && rect_empty);

  gfx_walker #(.VCELLS(VCELLS), .BPR(BPR), .GBYTES(GBYTES)) u_walk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .accept_i     (accept),
    .start_i      (start),
    .op_i         (op_dec),
    .bcol_first_i (bcol_first),
    .bcol_last_i  (bcol_last),
    .lmask_i      (lmask),
    .rmask_i      (rmask),
    .row_first_i  (prm.y0),
    .row_end_i    (row_end),
    .row_base_i   (row_base),
    .colour_i     (prm.colour),
    .cell_i       ({prm.attr, prm.chr}),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .vram_we_o    (vram_we_o),
    .vram_addr_o  (vram_addr_o),
    .vram_wdata_o (vram_wdata_o),
    .gram_we_o    (gram_we_o),
    .gram_addr_o  (gram_addr_o),
    .gram_wdata_o (gram_wdata_o),
    .gram_mask_o  (gram_mask_o)
  );
endmodule

// File: rtl/gfx_fill_engine_chk.sv
module gfx_fill_engine_chk #(
  parameter int unsigned VCELLS = 2000,
  parameter int unsigned GBYTES = 16000,
  localparam int unsigned VAW   = $clog2(VCELLS),
  localparam int unsigned GAW   = $clog2(GBYTES)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           busy_o,
  input logic           done_o,
  input logic           vram_we_o,
  input logic [VAW-1:0] vram_addr_o,
  input logic           gram_we_o,
  input logic [GAW-1:0] gram_addr_o,
  input logic [7:0]     gram_mask_o
);
  p_one_target_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vram_we_o && gram_we_o));

  p_vram_ascend_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vram_we_o && $past(vram_we_o)) |-> vram_addr_o == VAW'($past(vram_addr_o) + 1'b1));

  p_vram_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vram_we_o |-> vram_addr_o < VAW'(VCELLS));

  p_gram_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gram_we_o |-> gram_addr_o < GAW'(GBYTES));

  p_mask_nonzero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gram_we_o |-> gram_mask_o != 8'h00);

  p_done_low_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !done_o);

  p_done_fall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(done_o) |-> busy_o);
endmodule

bind gfx_fill_engine gfx_fill_engine_chk #(.VCELLS(VCELLS), .GBYTES(GBYTES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .vram_we_o   (vram_we_o),
  .vram_addr_o (vram_addr_o),
  .gram_we_o   (gram_we_o),
  .gram_addr_o (gram_addr_o),
  .gram_mask_o (gram_mask_o)
);

// File: tb/tb_gfx_fill_engine.sv
module tb_gfx_fill_engine;
  localparam int CLK_P = 10;
  localparam int SCR_W = 640;
  localparam int SCR_H = 200;
  localparam int NCELL = 2000;
  localparam int NBYTE = 16000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        param_we, cmd_we;
  logic [7:0]  param_data, cmd_data;
  logic        busy, done;
  logic        vram_we, gram_we;
  logic [10:0] vram_addr;
  logic [15:0] vram_wdata;
  logic [13:0] gram_addr;
  logic [23:0] gram_wdata;
  logic [7:0]  gram_mask;

  always #(CLK_P/2) clk = ~clk;

  gfx_fill_engine dut (
    .clk_i(clk), .rst_ni(rst_n),
    .param_we_i(param_we), .param_data_i(param_data),
    .cmd_we_i(cmd_we), .cmd_data_i(cmd_data),
    .busy_o(busy), .done_o(done),
    .vram_we_o(vram_we), .vram_addr_o(vram_addr), .vram_wdata_o(vram_wdata),
    .gram_we_o(gram_we), .gram_addr_o(gram_addr), .gram_wdata_o(gram_wdata),
    .gram_mask_o(gram_mask)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // bench view of the parameter file
  int p_x0, p_y0, p_w, p_h, p_col, p_chr, p_attr;

  // expected stream state: 0 none, 1 cells, 2 rect, 3 plane clear
  int e_kind, e_idx, e_y, e_ye, e_bc, e_bs, e_be, e_x0, e_xe, e_col, e_cell;
  int wr_cnt, busy_cycles, stream_err;
  int bad_act, bad_exp;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  function automatic int exp_mask(input int bc, input int x0, input int xe);
    int m = 0;
    for (int p = 0; p < 8; p++)
      if (bc*8 + p >= x0 && bc*8 + p < xe) m |= (1 << (7 - p));
    return m;
  endfunction

  function automatic int rect_writes(input int x0, input int y0, input int w, input int h);
    int xe = (x0 + w > SCR_W) ? SCR_W : x0 + w;
    int ye = (y0 + h > SCR_H) ? SCR_H : y0 + h;
    if (xe <= x0 || ye <= y0) return 0;
    return (ye - y0) * ((xe - 1) / 8 - x0 / 8 + 1);
  endfunction

  always @(posedge clk) begin
    if (vram_we || gram_we) begin
      int ea, em, ed, aa, am, ad;
      wr_cnt++;
      aa = vram_we ? int'(vram_addr) : int'(gram_addr);
      am = vram_we ? 255 : int'(gram_mask);
      ad = vram_we ? int'(vram_wdata) : int'(gram_wdata);
      ea = -1; em = 0; ed = 0;
      if (vram_we && e_kind == 1) begin
        ea = e_idx; em = 255; ed = e_cell; e_idx++;
      end else if (gram_we && e_kind == 3) begin
        ea = e_idx; em = 255; ed = 0; e_idx++;
      end else if (gram_we && e_kind == 2) begin
        ea = e_y * 80 + e_bc;
        em = exp_mask(e_bc, e_x0, e_xe);
        ed = ((e_col & 4) ? 32'hFF0000 : 0) | ((e_col & 2) ? 32'h00FF00 : 0) |
             ((e_col & 1) ? 32'h0000FF : 0);
        if (e_bc == e_be) begin e_bc = e_bs; e_y++; end
        else e_bc++;
      end
      if ((aa != ea || am != em || ad != ed) && stream_err == 0) begin
        bad_act = aa; bad_exp = ea;
        $display("  stream mismatch at write %0d: addr %0d/%0d mask %0h/%0h data %0h/%0h",
                 wr_cnt, aa, ea, am, em, ad, ed);
      end
      if (aa != ea || am != em || ad != ed) stream_err++;
    end
  end

  always @(negedge clk) if (busy) busy_cycles++;

  task automatic send_params(input int x0, input int y0, input int w, input int h,
                             input int col, input int chr, input int attr, input int n);
    logic [7:0] b [9];
    b[0] = x0[7:0]; b[1] = x0[15:8]; b[2] = y0[7:0]; b[3] = w[7:0]; b[4] = w[15:8];
    b[5] = h[7:0]; b[6] = col[7:0]; b[7] = chr[7:0]; b[8] = attr[7:0];
    for (int i = 0; i < n; i++) begin
      param_we = 1'b1; param_data = b[i];
      @(negedge clk);
    end
    param_we = 1'b0;
    if (n > 0) p_x0 = x0;
    if (n > 2) p_y0 = y0;
    if (n > 4) p_w = w;
    if (n > 5) p_h = h;
    if (n > 6) p_col = col & 7;
    if (n > 7) p_chr = chr;
    if (n > 8) p_attr = attr;
  endtask

  task automatic start_cmd(input logic [7:0] cmd, input int exp_n, input string req,
                           input bit pw, input logic [7:0] pd);
    e_kind = (cmd == 8'h01) ? 1 : (cmd == 8'h02) ? 2 : (cmd == 8'h03) ? 3 : 0;
    if (exp_n == 0) e_kind = 0;
    e_idx = 0; e_cell = (p_attr << 8) | p_chr; e_col = p_col;
    e_x0 = p_x0; e_xe = (p_x0 + p_w > SCR_W) ? SCR_W : p_x0 + p_w;
    e_y = p_y0; e_ye = (p_y0 + p_h > SCR_H) ? SCR_H : p_y0 + p_h;
    e_bs = p_x0 / 8; e_be = (e_xe - 1) / 8; e_bc = e_bs;
    wr_cnt = 0; busy_cycles = 0; stream_err = 0;
    cmd_we = 1'b1; cmd_data = cmd; param_we = pw; param_data = pd;
    @(negedge clk);
    cmd_we = 1'b0; param_we = 1'b0;
    check(busy == (exp_n > 0), {req, " R7 busy after command"}, busy, exp_n > 0);
    check(done == (exp_n == 0), {req, " R7 done after command"}, done, exp_n == 0);
  endtask

  task automatic finish_cmd(input int exp_n, input string req);
    int guard = 0;
    while (busy && guard < 20000) begin guard++; @(negedge clk); end
    check(busy_cycles == exp_n, {req, " R7 busy length"}, busy_cycles, exp_n);
    check(wr_cnt == exp_n, {req, " write count"}, wr_cnt, exp_n);
    check(stream_err == 0, {req, " address/mask/data stream"}, bad_act, bad_exp);
    check(done == 1'b1, {req, " R7 done at end"}, done, 1);
    @(negedge clk);
  endtask

  task automatic run_cmd(input logic [7:0] cmd, input int exp_n, input string req);
    start_cmd(cmd, exp_n, req, 1'b0, 8'h00);
    finish_cmd(exp_n, req);
  endtask

  task automatic rect(input int x0, input int y0, input int w, input int h, input int col,
                      input string req);
    send_params(x0, y0, w, h, col, p_chr, p_attr, 9);
    run_cmd(8'h02, rect_writes(x0, y0, w, h), req);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240611);
    rst_n = 1'b0; param_we = 1'b0; cmd_we = 1'b0; param_data = '0; cmd_data = '0;
    p_x0 = 0; p_y0 = 0; p_w = 0; p_h = 0; p_col = 0; p_chr = 0; p_attr = 0;
    e_kind = 0; wr_cnt = 0; stream_err = 0; bad_act = 0; bad_exp = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !done, "R1 busy/done at reset", {busy, done}, 0);
    check(!vram_we && !gram_we, "R1 write enables at reset", {vram_we, gram_we}, 0);

    // R3 character fill, R2 byte order
    send_params(0, 0, 0, 0, 0, 8'h41, 8'h71, 9);
    run_cmd(8'h01, NCELL, "R3 char fill");

    // R2 tenth byte dropped
    send_params(0, 0, 0, 0, 0, 8'h5A, 8'h1E, 9);
    param_we = 1'b1; param_data = 8'hEE; @(negedge clk); param_we = 1'b0;
    run_cmd(8'h01, NCELL, "R2 extra byte dropped");

    // R5 directed rectangles
    rect(3, 5, 10, 4, 5, "R5 two-byte rect");
    rect(17, 0, 3, 1, 2, "R5 single-byte interior");
    rect(8, 10, 64, 3, 7, "R5 aligned rect");
    rect(1, 199, 638, 1, 3, "R5 wide row");

    // R6 clipping and empty rectangles
    rect(630, 195, 50, 20, 6, "R6 clip right/bottom");
    rect(40, 40, 0, 5, 1, "R6 zero width");
    rect(700, 10, 20, 5, 1, "R6 x beyond edge");
    rect(10, 230, 20, 5, 1, "R6 y beyond edge");

    // R4 plane clear
    run_cmd(8'h03, NBYTE, "R4 plane clear");

    // R5/R6 random rectangles
    for (int i = 0; i < 10; i++) begin
      rect($urandom_range(0, 700), $urandom_range(0, 215), $urandom_range(0, 260),
           $urandom_range(0, 40), $urandom_range(0, 7), "R5 random rect");
    end

    // R8 command while busy
    send_params(0, 20, 640, 10, 4, p_chr, p_attr, 9);
    start_cmd(8'h02, 800, "R8 busy rect", 1'b0, 8'h00);
    repeat (5) @(negedge clk);
    cmd_we = 1'b1; cmd_data = 8'h03; @(negedge clk); cmd_we = 1'b0;
    finish_cmd(800, "R8 ignored command");

    // R9 unknown code
    run_cmd(8'h7E, 0, "R9 unknown code");
    run_cmd(8'h00, 0, "R9 code zero");

    // R10 parameter byte coincident with command
    send_params(0, 0, 0, 0, 0, 8'h22, 8'h00, 8);
    start_cmd(8'h01, NCELL, "R10 coincident write", 1'b1, 8'h33);
    finish_cmd(NCELL, "R10 old attribute used");
    p_attr = 8'h33;
    run_cmd(8'h01, NCELL, "R10 new attribute stored");

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule